// File: doc/BRIEF.md
# Boot Stream Loader

This block turns a byte-serial boot image into a series of byte writes to on-chip memory. Bytes arrive from an external storage reader on a valid/ready input channel. The first four bytes form a little-endian configuration word. Its upper nibble is a signature. The loader checks the signature so that it never loads from an erased or blank device. The word also carries the storage device's bus width, wait-state count, hold-time count and serial clock rate code. The loader holds these in registers for the surrounding boot logic to apply.

After the configuration word comes a chain of ten-byte block headers. Each header gives a destination address, a byte count and a flag word. The first block is a count block: its four payload bytes are kept as a status value and are not written to memory. Every later block is either copied from the stream to memory or written as zeros without reading any payload. Loading ends after the block flagged as final. Both channels follow valid/ready rules. A transfer happens on a clock edge where valid and ready are both high. While the memory port holds ready low, the pending write keeps its valid and address. During a copy, input ready follows memory ready, so stream bytes are consumed only as they are written.

Top module: `boot_loader`

## Requirements
- R1: The configuration word is bytes 0–3 of the stream, little-endian. If bits 31:28 are not 0xA, `error` rises and stays high. After that `done`, `wr_valid` and `in_ready` stay low and `cfg_valid` stays low.
- R2: After an accepted configuration word, `cfg_valid` goes high and the outputs take these fields: `cfg_wide` = bit 0, `cfg_wait` = bits 4:1, `cfg_hold` = bits 7:6, `cfg_rate` = bits 10:8. Before that they hold 0, 15, 3 and 0, and they do not change afterwards.
- R3: A block header is ten bytes, little-endian: destination address in bytes 0–3, count in bytes 4–7, flag word in bytes 8–9. Flag bit 0 selects zero-fill and flag bit 15 marks the final block. All other flag bits have no effect.
- R4: The first block after the configuration word is a count block. Its address, count and flags are ignored. Exactly four payload bytes follow it, and they are captured little-endian into `boot_count`. No memory write results from it.
- R5: A copy block writes its `count` payload bytes to consecutive addresses starting at its address. Each `wr_data` equals the stream byte.
- R6: A zero-fill block writes `count` zero bytes to consecutive addresses starting at its address. It consumes no stream bytes.
- R7: A block whose count is zero issues no writes and consumes no payload. The next header follows directly.
- R8: When the final block's writes complete, or straight after its header if its count is zero, `done` rises and stays high. No further stream bytes are accepted.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid` and `wr_addr` hold on the next cycle. During a copy, `in_ready` follows `wr_ready`.
- R10: After reset, `in_ready` is high and `wr_valid`, `done`, `error` and `cfg_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte available |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Loader accepts a stream byte |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Memory write byte address |
| wr_data | output | 8 | Memory write byte |
| wr_ready | input | 1 | Memory accepts the write |
| cfg_valid | output | 1 | Configuration fields are loaded |
| cfg_wide | output | 1 | Device width: 1 = 16-bit, 0 = 8-bit |
| cfg_wait | output | 4 | Device wait-state count |
| cfg_hold | output | 2 | Device hold-time cycle count |
| cfg_rate | output | 3 | Serial clock rate code |
| boot_count | output | CNT_W | Value captured from the count block |
| done | output | 1 | Final block processed |
| error | output | 1 | Signature rejected |

## Verification
Some rules are checked by assertions on every cycle: error and done are sticky, and they never appear together with a write. A stalled write holds its address. Write addresses step by one inside a block. The configuration stays frozen once it is valid. Other behaviour can only be shown by the bench's scenarios. These are the little-endian field decoding, the capture of the count-block value, and a zero-fill consuming no stream bytes. A zero-count block produces no writes, and bytes after the final block are left unconsumed. The scenarios compare the exact write sequence and the number of bytes accepted against values worked out from the stream.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef enum logic [2:0] {
    S_GH, S_BHDR, S_BDEC, S_CPAY, S_COPY, S_FILL, S_DONE, S_ERR
  } bl_state_e;

  typedef struct packed {
    logic [2:0] rate;
    logic [1:0] hold;
    logic [3:0] waits;
    logic       wide;
  } bl_cfg_t;

  localparam bl_cfg_t CFG_RST = '{rate: 3'd0, hold: 2'd3, waits: 4'd15, wide: 1'b0};

  localparam int GH_BYTES   = 4;
  localparam int HDR_BYTES  = 10;
  localparam int CPAY_BYTES = 4;
endpackage

// File: rtl/bl_gh_decode.sv
module bl_gh_decode
  import bl_pkg::*;
#(
  parameter logic [3:0] SIG = 4'hA
) (
  input  logic [9:0] fields,   // {word[10:6], word[4:0]}
  input  logic [3:0] sig,      // word[31:28]
  output bl_cfg_t    cfg,
  output logic       sig_ok
);
  always_comb begin
    cfg.wide  = fields[0];
    cfg.waits = fields[4:1];
    cfg.hold  = fields[6:5];
    cfg.rate  = fields[9:7];
    sig_ok    = (sig == SIG);
  end
endmodule

// File: rtl/bl_hdr_shift.sv
module bl_hdr_shift
  import bl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] f_addr,
  output logic [CNT_W-1:0]  f_cnt,
  output logic              f_zero,
  output logic              f_final,
  output logic [23:0]       f_top24
);
  localparam int SR_W = HDR_BYTES * 8;

  logic [SR_W-1:0] sr;

  // newest byte enters at the top, so after N pushes the little-endian
  // value of the last N bytes sits in the top N bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (push) sr <= {din, sr[SR_W-1:8]};
  end

  assign f_addr  = sr[ADDR_W-1:0];
  assign f_cnt   = sr[32 +: CNT_W];
  assign f_zero  = sr[64];
  assign f_final = sr[79];
  assign f_top24 = sr[SR_W-1 -: 24];

  a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sr[SR_W-1 -: 8] == $past(din));
endmodule

// File: rtl/bl_wr_ctr.sv
module bl_wr_ctr #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      rem_q <= '0;
    end else if (load) begin
      addr  <= load_addr;
      rem_q <= load_cnt;
    end else if (step) begin
      addr  <= addr + ADDR_W'(1);
      rem_q <= rem_q - CNT_W'(1);
    end
  end

  assign last = (rem_q == CNT_W'(1));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && !load) |=> addr == $past(addr) + ADDR_W'(1));
endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import bl_pkg::*;
#(
  parameter int         ADDR_W = 32,
  parameter int         CNT_W  = 32,
  parameter logic [3:0] SIG    = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_ready,
  output logic              cfg_valid,
  output logic              cfg_wide,
  output logic [3:0]        cfg_wait,
  output logic [1:0]        cfg_hold,
  output logic [2:0]        cfg_rate,
  output logic [CNT_W-1:0]  boot_count,
  output logic              done,
  output logic              error
);
  localparam int IDX_W = $clog2(HDR_BYTES + 1);
  localparam logic [IDX_W-1:0] GH_LAST   = IDX_W'(GH_BYTES - 1);
  localparam logic [IDX_W-1:0] HDR_LAST  = IDX_W'(HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] CPAY_LAST = IDX_W'(CPAY_BYTES - 1);

  bl_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             first_q;
  bl_cfg_t          cfg_q, cfg_dec;
  logic             cfg_v_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sig_ok;

  logic              accept, push, step, load, last;
  logic [ADDR_W-1:0] f_addr;
  logic [CNT_W-1:0]  f_cnt;
  logic              f_zero, f_final;
  logic [23:0]       f_top24;
  logic [31:0]       word4;

  // ---------------- handshakes ----------------
  always_comb begin
    case (state)
      S_GH, S_BHDR, S_CPAY: in_ready = 1'b1;
      S_COPY:               in_ready = wr_ready;
      default:              in_ready = 1'b0;
    endcase
  end

  always_comb begin
    case (state)
      S_COPY:  begin wr_valid = in_valid; wr_data = in_data; end
      S_FILL:  begin wr_valid = 1'b1;     wr_data = 8'h00;   end
      default: begin wr_valid = 1'b0;     wr_data = 8'h00;   end
    endcase
  end

  assign accept = in_valid && in_ready;
  assign push   = accept && (state != S_COPY);
  assign step   = wr_valid && wr_ready;
  assign load   = (state == S_BDEC);
  assign word4  = {in_data, f_top24};

  // ---------------- datapath pieces ----------------
  bl_hdr_shift #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_shift (
    .clk, .rst_n, .push, .din(in_data),
    .f_addr, .f_cnt, .f_zero, .f_final, .f_top24
  );

  bl_gh_decode #(.SIG(SIG)) u_dec (
    .fields({word4[10:6], word4[4:0]}),
    .sig(word4[31:28]),
    .cfg(cfg_dec),
    .sig_ok
  );

  bl_wr_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
    .clk, .rst_n, .load,
    .load_addr(f_addr), .load_cnt(f_cnt),
    .step, .addr(wr_addr), .last
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_GH;
      idx     <= '0;
      first_q <= 1'b0;
      cfg_q   <= CFG_RST;
      cfg_v_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (state)
        S_GH: if (accept) begin
          if (idx == GH_LAST) begin
            idx <= '0;
            if (sig_ok) begin
              cfg_q   <= cfg_dec;
              cfg_v_q <= 1'b1;
              first_q <= 1'b1;
              state   <= S_BHDR;
            end else begin
              state <= S_ERR;
            end
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        S_BHDR: if (accept) begin
          if (idx == HDR_LAST) begin
            idx   <= '0;
            state <= S_BDEC;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        S_BDEC: begin
          if (first_q)                state <= S_CPAY;
          else if (f_cnt == '0)       state <= f_final ? S_DONE : S_BHDR;
          else                        state <= f_zero ? S_FILL : S_COPY;
        end
        S_CPAY: if (accept) begin
          if (idx == CPAY_LAST) begin
            cnt_q   <= CNT_W'(word4);
            first_q <= 1'b0;
            idx     <= '0;
            state   <= S_BHDR;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        S_COPY, S_FILL: if (step && last) begin
          state <= f_final ? S_DONE : S_BHDR;
        end
        default: state <= state;
      endcase
    end
  end

  assign cfg_valid  = cfg_v_q;
  assign cfg_wide   = cfg_q.wide;
  assign cfg_wait   = cfg_q.waits;
  assign cfg_hold   = cfg_q.hold;
  assign cfg_rate   = cfg_q.rate;
  assign boot_count = cnt_q;
  assign done       = (state == S_DONE);
  assign error      = (state == S_ERR);

  // ---------------- assertions ----------------
  a_r1_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!wr_valid && !done && !in_ready && !cfg_valid));
  a_r1_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !in_ready && !wr_valid));
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> (cfg_valid && $stable(cfg_wide) && $stable(cfg_wait)
                   && $stable(cfg_hold) && $stable(cfg_rate)));
endmodule

// File: tb/sim_boot_loader.sv
module sim_boot_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_ready = 1'b1;
  logic        cfg_valid, cfg_wide;
  logic [3:0]  cfg_wait;
  logic [1:0]  cfg_hold;
  logic [2:0]  cfg_rate;
  logic [31:0] boot_count;
  logic        done, error;

  always #5 clk = ~clk;

  boot_loader u0 (
    .clk, .rst_n, .in_valid, .in_data, .in_ready,
    .wr_valid, .wr_addr, .wr_data, .wr_ready,
    .cfg_valid, .cfg_wide, .cfg_wait, .cfg_hold, .cfg_rate,
    .boot_count, .done, .error
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int nacc = 0;
  int stall_bad = 0;
  bit stall_mode = 0;
  bit prev_stall = 0;
  logic [31:0] prev_addr = '0;
  logic [7:0]  lfsr = 8'h5B;

  logic [7:0]  stream[$];
  logic [31:0] ea[$];
  logic [7:0]  ed[$];
  logic [31:0] la[$];
  logic [7:0]  ld[$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write-port back-pressure pattern
  always @(posedge clk) begin
    #1;
    if (stall_mode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_ready = lfsr[0] | lfsr[2];
    end else begin
      wr_ready = 1'b1;
    end
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (wr_valid && wr_ready) begin la.push_back(wr_addr); ld.push_back(wr_data); end
      if (in_valid && in_ready) nacc++;
      if (prev_stall && !(wr_valid && wr_addr == prev_addr)) stall_bad++;
      prev_stall = wr_valid && !wr_ready;
      prev_addr  = wr_addr;
    end else begin
      prev_stall = 0;
    end
    if (cycles == 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    stream.delete(); ea.delete(); ed.delete(); la.delete(); ld.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    nacc = 0; stall_bad = 0;
  endtask

  task automatic put32(input logic [31:0] w);
    for (int i = 0; i < 4; i++) stream.push_back(w[8*i +: 8]);
  endtask

  task automatic put_hdr(input logic [31:0] a, input logic [31:0] c, input logic [15:0] f);
    put32(a); put32(c);
    stream.push_back(f[7:0]); stream.push_back(f[15:8]);
  endtask

  task automatic exp_run(input logic [31:0] a, input int n, input logic [7:0] d0, input bit zero);
    for (int i = 0; i < n; i++) begin
      ea.push_back(a + i);
      ed.push_back(zero ? 8'h00 : d0 + 8'(i));
    end
  endtask

  task automatic run_stream();
    bit got;
    for (int i = 0; i < stream.size(); i++) begin
      in_valid = 1'b1;
      in_data  = stream[i];
      got = 0;
      while (!got) begin
        @(negedge clk);
        got = in_ready;
        if (done || error) break;
        @(posedge clk); #1;
      end
      if (done || error) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int k = 0; k < 2000 && !(done || error); k++) @(posedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_writes(input string req);
    check({req, " write count"}, la.size(), ea.size());
    for (int i = 0; i < ea.size() && i < la.size(); i++) begin
      check({req, " addr"}, la[i], ea[i]);
      check({req, " data"}, ld[i], ed[i]);
    end
  endtask

  // R10 / R2: reset state
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R10 in_ready", in_ready, 1);
    check("R10 wr_valid", wr_valid, 0);
    check("R10 done", done, 0);
    check("R10 error", error, 0);
    check("R10 cfg_valid", cfg_valid, 0);
    check("R2 reset wait", cfg_wait, 15);
    check("R2 reset hold", cfg_hold, 3);
    check("R2 reset wide", cfg_wide, 0);
    check("R2 reset rate", cfg_rate, 0);
  endtask

  // R1: bad signature
  task automatic t_bad_sig();
    do_reset();
    put32(32'h5000_028D);
    put_hdr(32'h0, 32'h4, 16'h0);
    run_stream();
    check("R1 error", error, 1);
    check("R1 no done", done, 0);
    check("R1 no cfg_valid", cfg_valid, 0);
    check("R1 in_ready low", in_ready, 0);
    check("R1 bytes taken", nacc, 4);
    check("R1 writes", la.size(), 0);
  endtask

  // R2..R9: main chain; alt exercises ignored flag bits and final zero-fill
  task automatic t_chain(input bit alt);
    do_reset();
    stall_mode = alt;
    put32(32'hA000_028D);                       // wide=1 wait=6 hold=2 rate=2
    put_hdr(32'hDEAD_BEEF, 32'd4, 16'h8001);    // count block, flags ignored (R4)
    put32(32'h1234_5678);
    put_hdr(32'h100, 32'd3, alt ? 16'h7FFE : 16'h0000);
    stream.push_back(8'h11); stream.push_back(8'h12); stream.push_back(8'h13);
    put_hdr(32'h200, 32'd2, 16'h0001);          // zero-fill
    put_hdr(32'h300, 32'd0, 16'h0000);          // empty
    if (alt) put_hdr(32'h400, 32'd3, 16'h8001); // final zero-fill
    else begin
      put_hdr(32'h400, 32'd2, 16'h8000);
      stream.push_back(8'hAA); stream.push_back(8'hAB);
    end
    stream.push_back(8'hEE); stream.push_back(8'hEF);
    exp_run(32'h100, 3, 8'h11, 0);
    exp_run(32'h200, 2, 8'h00, 1);
    if (alt) exp_run(32'h400, 3, 8'h00, 1);
    else     exp_run(32'h400, 2, 8'hAA, 0);
    run_stream();
    check("R2 cfg_valid", cfg_valid, 1);
    check("R2 wide", cfg_wide, 1);
    check("R2 wait", cfg_wait, 6);
    check("R2 hold", cfg_hold, 2);
    check("R2 rate", cfg_rate, 2);
    check("R4 boot_count", boot_count, 32'h1234_5678);
    cmp_writes(alt ? "R3 R5 R6 R7" : "R5 R6 R7");
    check("R6 R8 bytes taken", nacc, alt ? 61 : 63);
    check("R8 done", done, 1);
    check("R8 in_ready low", in_ready, 0);
    check("R1 no error", error, 0);
    check("R9 stall hold", stall_bad, 0);
    stall_mode = 0;
  endtask

  // R7 / R8: final block with zero count
  task automatic t_final_empty();
    do_reset();
    put32(32'hA000_0000);
    put_hdr(32'h0, 32'd4, 16'h0000);
    put32(32'hCAFE_0001);
    put_hdr(32'h500, 32'd0, 16'h8000);
    stream.push_back(8'h99);
    run_stream();
    check("R8 empty final done", done, 1);
    check("R7 empty final writes", la.size(), 0);
    check("R7 bytes taken", nacc, 28);
    check("R4 boot_count", boot_count, 32'hCAFE_0001);
    check("R2 wide 8-bit", cfg_wide, 0);
  endtask

  initial begin
    t_reset();
    t_bad_sig();
    t_chain(0);
    t_chain(1);
    t_final_empty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule